// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O

The block gives a host three 8-bit parallel ports, called A, B and C. The host reaches them over a small synchronous register bus. That bus has an active-low chip select, a two-bit register address, active-low read and write strobes, and an 8-bit write and read data path. Each port pin has its own input, output value and output-enable wire. The pad ring builds the bidirectional pins from these three wires. Port C splits into an upper nibble and a lower nibble, and each nibble takes its own direction.

The host writes to the control address in one of two formats, chosen by bit 7. With bit 7 set, the byte is a configuration word: it sets the directions of the four groups and resets every output latch. With bit 7 clear, the byte sets or clears one chosen port C latch bit, and the configuration stays as it was. Only basic operation is built. Each port or nibble is either wholly input or wholly output. The group mode fields are kept, but they never change how the pins behave.

A write takes effect on the clock edge that samples it. A read is combinational from the strobes and the address.

Top module: `tri_port_pio`

## Requirements
- R1: The address selects the target: 00 is port A, 01 is port B, 10 is port C and 11 is the control register. A read of address 11 returns 0x00.
- R2: While cs_n is high, the write strobe changes nothing and rdata_oe stays low.
- R3: After reset every output-enable is low and every output latch is zero.
- R4: A control write with bit 7 = 1 sets the group directions: bit 4 sets port A, bit 1 port B, bit 3 the port C upper nibble and bit 0 the port C lower nibble. A direction bit of 1 makes the group input (enables 0) and 0 makes it output (enables all 1).
- R5: The mode fields of a configuration word (bits 6:5 for group A, bit 2 for group B) have no effect on pin behaviour. A group that is set to output drives its latch in every mode value.
- R6: A control write with bit 7 = 0 writes bit 0 into the port C latch bit whose index is given by bits 3:1. No other latch bit and no direction changes.
- R7: Each configuration word (bit 7 = 1) clears the A, B and C output latches to zero.
- R8: A port read returns the live pin value for input bits and the output latch for output bits. Port C chooses this per nibble.
- R9: A data write to a port updates only the latch bits that are configured as output. With port C mixed, only its output nibble changes.
- R10: rdata_oe is high only while cs_n and rd_n are both low, and rdata is 0x00 whenever rdata_oe is low.
- R11: A write occurs on each rising clock edge at which cs_n and wr_n are both low. Its result shows on the outputs from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data to host |
| rdata_oe | output | 1 | Read data valid / bus drive enable |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
When port C is configured with one nibble output and the other input, a single read merges two sources: the latch for the output nibble and the live pins for the input nibble. The bench sets up this split in both orientations. It uses bit set/reset commands and data writes to load known latch values, drives pin values that differ from the latch, and checks the merged read byte nibble by nibble. It also checks that a data write in this state leaves the input nibble's latch bits untouched.

// File: rtl/pio_pkg.sv
// Shared types for the three-port parallel I/O.
// Assumes an 8-bit control word; the data width of the ports is set in the modules.
package pio_pkg;

    typedef enum logic [1:0] {
        SEL_A    = 2'b00,
        SEL_B    = 2'b01,
        SEL_C    = 2'b10,
        SEL_CTRL = 2'b11
    } port_sel_e;

    // Direction flags, 1 = input
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic cu_in;
        logic cl_in;
    } dir_t;

endpackage

// File: rtl/pio_ctrl_reg.sv
// Control register: decodes the two control-write formats.
// Holds the group directions and the (inert) mode fields.
// Emits a latch-clear pulse for configuration words and a bit-write command for port C.
// Assumes that wr_ctrl is already qualified by chip select and the address.
module pio_ctrl_reg
    import pio_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic [CW-1:0] wdata,
    output dir_t          dir,
    output logic [1:0]    mode_a,
    output logic          mode_b,
    output logic          cfg_load,
    output logic          bit_cmd,
    output logic [2:0]    bit_idx,
    output logic          bit_val
);
    dir_t       dir_q;
    logic [1:0] mode_a_q;
    logic       mode_b_q;

    // Split a control write into its two formats
    always_comb begin
        cfg_load = wr_ctrl &  wdata[7];
        bit_cmd  = wr_ctrl & ~wdata[7];
        bit_idx  = wdata[3:1];
        bit_val  = wdata[0];
    end

    // Store directions and mode fields on a configuration word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
            mode_a_q <= 2'b00;
            mode_b_q <= 1'b0;
        end else if (cfg_load) begin
            dir_q    <= '{a_in: wdata[4], b_in: wdata[1], cu_in: wdata[3], cl_in: wdata[0]};
            mode_a_q <= wdata[6:5];
            mode_b_q <= wdata[2];
        end
    end

    assign dir    = dir_q;
    assign mode_a = mode_a_q;
    assign mode_b = mode_b_q;

    // R6: a bit command leaves the directions alone
    a_r6_bit_cmd_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cmd |=> $stable(dir_q));

endmodule

// File: rtl/pio_port_reg.sv
// One port's output latch.
// A data write merges through the output-enable mask.
// A clear pulse zeroes the latch, and an optional single-bit write acts on one chosen bit.
// Assumes that clear, write and bit command are never active together (one bus access per cycle).
module pio_port_reg #(
    parameter int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  oe_mask,
    input  logic          bit_en,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  lat
);
    // Latch update: reset, clear, masked write, single-bit write
    always_ff @(posedge clk) begin
        if (!rst_n)      lat <= '0;
        else if (clr)    lat <= '0;
        else if (wr)     lat <= (lat & ~oe_mask) | (wdata & oe_mask);
        else if (bit_en) lat[bit_idx] <= bit_val;
    end

    // R7: a configuration word leaves the latch at zero
    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lat == '0));

    // R9: a data write never touches the input bits
    a_r9_input_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> ((lat & ~$past(oe_mask)) == ($past(lat) & ~$past(oe_mask))));

endmodule

// File: rtl/pio_rd_mux.sv
// Read path: picks the addressed port and merges pins and latch per bit by direction.
// Gates the result with chip select and the read strobe.
// Assumes that the control address reads as zero.
module pio_rd_mux
    import pio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   addr,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic [W-1:0] pa_in,
    input  logic [W-1:0] pa_lat,
    input  logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_in,
    input  logic [W-1:0] pb_lat,
    input  logic [W-1:0] pb_oe,
    input  logic [W-1:0] pc_in,
    input  logic [W-1:0] pc_lat,
    input  logic [W-1:0] pc_oe,
    output logic [W-1:0] rdata,
    output logic         rdata_oe
);
    logic [W-1:0] sel_val;

    // Select the addressed port: output bits show the latch, input bits the pins
    always_comb begin
        unique case (port_sel_e'(addr))
            SEL_A:   sel_val = (pa_in & ~pa_oe) | (pa_lat & pa_oe);
            SEL_B:   sel_val = (pb_in & ~pb_oe) | (pb_lat & pb_oe);
            SEL_C:   sel_val = (pc_in & ~pc_oe) | (pc_lat & pc_oe);
            default: sel_val = '0;
        endcase
    end

    // Drive the read bus only during a selected read
    always_comb begin
        rdata_oe = ~cs_n & ~rd_n;
        rdata    = rdata_oe ? sel_val : '0;
    end

endmodule

// File: rtl/tri_port_pio.sv
// Three-port programmable parallel I/O, basic mode only.
// Decodes the register bus and holds the configuration and the three output latches.
// Builds per-pin output enables and the read path.
// Assumes a synchronous host: one access is sampled on each rising edge while selected.
module tri_port_pio
    import pio_pkg::*;
#(
    parameter int DW = 8,
    localparam int NIB = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);
    logic       wr_fire;
    logic       wr_a, wr_b, wr_c, wr_ctrl;
    dir_t       dir;
    logic [1:0] mode_a;
    logic       mode_b;
    logic       cfg_load, bit_cmd, bit_val;
    logic [2:0] bit_idx;

    // Write decode by address
    always_comb begin
        wr_fire = ~cs_n & ~wr_n;
        wr_a    = wr_fire && (port_sel_e'(addr) == SEL_A);
        wr_b    = wr_fire && (port_sel_e'(addr) == SEL_B);
        wr_c    = wr_fire && (port_sel_e'(addr) == SEL_C);
        wr_ctrl = wr_fire && (port_sel_e'(addr) == SEL_CTRL);
    end

    // Output enables from the group directions
    always_comb begin
        pa_oe = {DW{~dir.a_in}};
        pb_oe = {DW{~dir.b_in}};
        pc_oe = {{NIB{~dir.cu_in}}, {NIB{~dir.cl_in}}};
    end

    pio_ctrl_reg #(.CW(8)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata[7:0]),
        .dir(dir), .mode_a(mode_a), .mode_b(mode_b),
        .cfg_load(cfg_load), .bit_cmd(bit_cmd), .bit_idx(bit_idx), .bit_val(bit_val)
    );

    pio_port_reg #(.W(DW)) port_a_i (
        .clk(clk), .rst_n(rst_n), .clr(cfg_load), .wr(wr_a), .wdata(wdata),
        .oe_mask(pa_oe), .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0), .lat(pa_out)
    );

    pio_port_reg #(.W(DW)) port_b_i (
        .clk(clk), .rst_n(rst_n), .clr(cfg_load), .wr(wr_b), .wdata(wdata),
        .oe_mask(pb_oe), .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0), .lat(pb_out)
    );

    pio_port_reg #(.W(DW)) port_c_i (
        .clk(clk), .rst_n(rst_n), .clr(cfg_load), .wr(wr_c), .wdata(wdata),
        .oe_mask(pc_oe), .bit_en(bit_cmd), .bit_idx(bit_idx[$clog2(DW)-1:0]),
        .bit_val(bit_val), .lat(pc_out)
    );

    pio_rd_mux #(.W(DW)) rd_i (
        .addr(addr), .cs_n(cs_n), .rd_n(rd_n),
        .pa_in(pa_in), .pa_lat(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_lat(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_lat(pc_out), .pc_oe(pc_oe),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // R2: no bus drive while deselected
    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!rdata_oe && rdata == '0));

    // R2: a deselected write strobe leaves every latch unchanged
    a_r2_deselect_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

    // R4: port A and B enables are all-or-nothing
    a_r4_whole_port: assert property (@(posedge clk) disable iff (!rst_n)
        ((pa_oe == '0) || (pa_oe == '1)) && ((pb_oe == '0) || (pb_oe == '1)));

    // R5: stored mode fields never change how the pins are driven
    a_r5_mode_inert: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_a != 2'b00) || mode_b) |-> (pa_oe == {DW{~dir.a_in}}));

    // R10: the read bus drives only on a selected read
    a_r10_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (!cs_n && !rd_n));

endmodule

// File: tb/tri_port_pio_tb.sv
// Directed bench for tri_port_pio. Each scenario task checks its own results.
module tri_port_pio_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tri_port_pio dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write access, sampled on a single rising edge; returns just after the next falling edge
    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        #1;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #2;
        d = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        #1;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R3 pa_oe", pa_oe, 8'h00);
        check("R3 pb_oe", pb_oe, 8'h00);
        check("R3 pc_oe", pc_oe, 8'h00);
        check("R3 latches", pa_out | pb_out | pc_out, 8'h00);
        pa_in = 8'hC3;
        bus_rd(2'b00, d);
        check("R8 input read pins", d, 8'hC3);
    endtask

    task automatic t_outputs;
        logic [7:0] d;
        bus_wr(2'b11, 8'h80);
        check("R4 pa_oe out", pa_oe, 8'hFF);
        check("R4 pb_oe out", pb_oe, 8'hFF);
        check("R4 pc_oe out", pc_oe, 8'hFF);
        bus_wr(2'b00, 8'h5A);
        check("R11 pa_out", pa_out, 8'h5A);
        pa_in = 8'h11;
        bus_rd(2'b00, d);
        check("R8 output read latch", d, 8'h5A);
        bus_wr(2'b01, 8'h3C);
        check("R1 port B", pb_out, 8'h3C);
        bus_wr(2'b10, 8'h81);
        check("R1 port C", pc_out, 8'h81);
        check("R1 A untouched", pa_out, 8'h5A);
        bus_rd(2'b11, d);
        check("R1 control read", d, 8'h00);
        bus_wr(2'b11, 8'h80);
        check("R7 clear A", pa_out, 8'h00);
        check("R7 clear B", pb_out, 8'h00);
        check("R7 clear C", pc_out, 8'h00);
    endtask

    task automatic t_modes;
        bus_wr(2'b11, 8'hE4);
        check("R5 pa_oe", pa_oe, 8'hFF);
        check("R5 pb_oe", pb_oe, 8'hFF);
        bus_wr(2'b00, 8'hA5);
        check("R5 pa_out", pa_out, 8'hA5);
        bus_wr(2'b01, 8'h96);
        check("R5 pb_out", pb_out, 8'h96);
    endtask

    task automatic t_bitcmd;
        bus_wr(2'b11, 8'h80);
        bus_wr(2'b11, 8'h0B);
        check("R6 set bit5", pc_out, 8'h20);
        bus_wr(2'b11, 8'h01);
        check("R6 set bit0", pc_out, 8'h21);
        bus_wr(2'b11, 8'h0F);
        check("R6 set bit7", pc_out, 8'hA1);
        bus_wr(2'b11, 8'h0A);
        check("R6 clear bit5", pc_out, 8'h81);
        check("R6 dir kept", pc_oe, 8'hFF);
    endtask

    task automatic t_mixed_c;
        logic [7:0] d;
        bus_wr(2'b11, 8'h81);
        check("R4 C lower in", pc_oe, 8'hF0);
        bus_wr(2'b10, 8'hFF);
        check("R9 C upper only", pc_out, 8'hF0);
        pc_in = 8'h3A;
        bus_rd(2'b10, d);
        check("R8 C merge lo-in", d, 8'hFA);
        bus_wr(2'b11, 8'h88);
        check("R4 C upper in", pc_oe, 8'h0F);
        bus_wr(2'b11, 8'h05);
        bus_wr(2'b10, 8'hC6);
        check("R9 C lower only", pc_out, 8'h06);
        pc_in = 8'h9F;
        bus_rd(2'b10, d);
        check("R8 C merge hi-in", d, 8'h96);
    endtask

    task automatic t_input_write;
        bus_wr(2'b11, 8'h90);
        check("R4 A input", pa_oe, 8'h00);
        bus_wr(2'b00, 8'h77);
        check("R9 input latch kept", pa_out, 8'h00);
    endtask

    task automatic t_deselect;
        logic [7:0] d;
        bus_wr(2'b11, 8'h80);
        bus_wr(2'b00, 8'h42);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'b00; wdata = 8'hBD;
        @(negedge clk);
        wr_n = 1'b1;
        #1;
        check("R2 no write", pa_out, 8'h42);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0;
        #2;
        check("R2 no drive", {7'b0, rdata_oe}, 8'h00);
        check("R10 rdata zero", rdata, 8'h00);
        rd_n = 1'b1; cs_n = 1'b0;
        #2;
        check("R10 no read strobe", {7'b0, rdata_oe}, 8'h00);
        cs_n = 1'b1;
        bus_rd(2'b00, d);
        check("R10 selected read", d, 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_outputs();
        t_modes();
        t_bitcmd();
        t_mixed_c();
        t_input_write();
        t_deselect();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule